// File: doc/BRIEF.md
# Banked GPIO Port with Masked Output Writes

This block is a general-purpose I/O port of 24 pins, grouped as three banks of eight. A host reaches it through a byte-wide register interface made of an address, write data, a write strobe and a combinational read-data bus. Each pin has a direction bit and an output value bit. It also has a drive style: push-pull, drive-low-only (open-drain) or drive-high-only (open-source). The port produces a per-pin output value and output enable for tri-state pads. It samples the pad levels back through a two-stage synchroniser.

Output values never need a read-modify-write. The host first writes a value byte to a bank and then the mask byte beside it. Only the pins whose mask bit is 1 take the staged value. A value byte written on its own is held and changes no pin. Pin n belongs to bank n/8 at bit n%8. The per-bank value registers sit two addresses apart, so each value byte and its mask byte form a pair.

Top module: `gpio_port_masked`

## Requirements
- R1: After reset every pad output value and output enable is 0. Direction (0x08 + bank), drive-mode (0x10 + 2*bank) and open-enable (0x11 + 2*bank) registers all read 0.
- R2: A write to the mask byte (address 2*bank + 1) sets each pin whose mask bit is 1 to the matching bit of the last value byte written to that bank. Pins whose mask bit is 0 keep their value. The staged value byte stays in place for later mask writes.
- R3: A write to a value byte (address 2*bank) alone changes no pad output value.
- R4: Direction bit 1 makes a pin an output and 0 an input. The direction register reads back what was written. An input pin never has output enable set.
- R5: With open-enable 0 (push-pull), an output pin has output enable set whether its value is 0 or 1.
- R6: With open-enable 1 and drive-mode bit 0 (open-drain), an output pin has output enable set only while its value is 0.
- R7: With open-enable 1 and drive-mode bit 1 (open-source), an output pin has output enable set only while its value is 1.
- R8: Reading a value byte address returns the pad input levels of that bank as sampled through two flops. A pad change shows after the second rising clock edge and not after the first.
- R9: Pin n maps to bank n/8, bit n%8. A write to one bank leaves the other banks' pins unchanged.
- R10: The drive-mode and open-enable registers read back their written contents at their own interleaved addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data byte |
| we | input | 1 | Write strobe, one byte per cycle |
| rdata | output | 8 | Read data for the current address |
| pad_in | input | 24 | Pad input levels, asynchronous |
| pad_out | output | 24 | Per-pin output value |
| pad_oe | output | 24 | Per-pin output enable |

## Verification
Two functions can fall in the same cycle: a masked write that changes a bank's output values, and an asynchronous change on the pad inputs of that same bank. The bench applies both in one cycle, with new pad levels and a mask write to bank 0 issued together. After the first edge, the output values must already carry the staged byte while the read-back level of bank 0 still shows the old pad state. Only after the second edge may all three banks read the new pad pattern.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_VALUE,
      SEL_MASK,
      SEL_DIR,
      SEL_MODE,
      SEL_OPEN
   } reg_sel_e;

   typedef enum logic [1:0] {
      DRV_PUSH_PULL,
      DRV_SINK_ONLY,
      DRV_SOURCE_ONLY
   } drive_e;

   function automatic drive_e drive_of(input logic open_en, input logic mode_bit);
      if (!open_en)
         return DRV_PUSH_PULL;
      else if (mode_bit)
         return DRV_SOURCE_ONLY;
      else
         return DRV_SINK_ONLY;
   endfunction

   function automatic logic pin_enable(input logic is_out, input drive_e drv, input logic val);
      logic en;
      if (!is_out)
         en = 1'b0;
      else begin
         case (drv)
            DRV_PUSH_PULL:   en = 1'b1;
            DRV_SINK_ONLY:   en = ~val;
            DRV_SOURCE_ONLY: en = val;
            default:         en = 1'b0;
         endcase
      end
      return en;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int NBANKS     = 3,
   parameter int VALUE_BASE = 0,
   parameter int DIR_BASE   = 8,
   parameter int MODE_BASE  = 16,
   localparam int BIDX_W    = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [BIDX_W-1:0] bank
);

   localparam int OPEN_BASE = MODE_BASE + 1;

   always_comb begin
      sel  = SEL_NONE;
      bank = '0;
      for (int b = 0; b < NBANKS; b++) begin
         if (addr == ADDR_W'(VALUE_BASE + 2*b)) begin
            sel  = SEL_VALUE;
            bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(VALUE_BASE + 2*b + 1)) begin
            sel  = SEL_MASK;
            bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(DIR_BASE + b)) begin
            sel  = SEL_DIR;
            bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(MODE_BASE + 2*b)) begin
            sel  = SEL_MODE;
            bank = BIDX_W'(b);
         end
         if (addr == ADDR_W'(OPEN_BASE + 2*b)) begin
            sel  = SEL_OPEN;
            bank = BIDX_W'(b);
         end
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] wdata,
   input  logic              wr_value,
   input  logic              wr_mask,
   input  logic              wr_dir,
   input  logic              wr_mode,
   input  logic              wr_open,
   output logic [BANK_W-1:0] out_q,
   output logic [BANK_W-1:0] oe,
   output logic [BANK_W-1:0] dir_q,
   output logic [BANK_W-1:0] mode_q,
   output logic [BANK_W-1:0] open_q
);

   logic [BANK_W-1:0] staged_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= '0;
         out_q    <= '0;
         dir_q    <= '0;
         mode_q   <= '0;
         open_q   <= '0;
      end else begin
         if (wr_value) staged_q <= wdata;
         if (wr_mask)  out_q    <= (out_q & ~wdata) | (staged_q & wdata);
         if (wr_dir)   dir_q    <= wdata;
         if (wr_mode)  mode_q   <= wdata;
         if (wr_open)  open_q   <= wdata;
      end
   end

   for (genvar p = 0; p < BANK_W; p++) begin : g_pin
      drive_e drv;
      assign drv   = drive_of(open_q[p], mode_q[p]);
      assign oe[p] = pin_enable(dir_q[p], drv, out_q[p]);
   end

endmodule

// File: rtl/gpio_port_masked.sv
module gpio_port_masked
   import gpio_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int NBANKS      = 3,
   parameter int BANK_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VALUE_BASE  = 0,
   parameter int DIR_BASE    = 8,
   parameter int MODE_BASE   = 16,
   localparam int NPINS      = NBANKS * BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] wdata,
   input  logic              we,
   output logic [BANK_W-1:0] rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);

   localparam int BIDX_W   = (NBANKS > 1) ? $clog2(NBANKS) : 1;
   localparam int TOP_ADDR = MODE_BASE + 2*NBANKS;

   if (NBANKS < 1) begin : g_bad_banks
      $error("gpio_port_masked: NBANKS must be at least 1");
   end
   if (VALUE_BASE + 2*NBANKS > DIR_BASE) begin : g_bad_dir
      $error("gpio_port_masked: direction region overlaps value region");
   end
   if (DIR_BASE + NBANKS > MODE_BASE) begin : g_bad_mode
      $error("gpio_port_masked: mode region overlaps direction region");
   end
   if (TOP_ADDR > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_port_masked: register map exceeds address width");
   end

   reg_sel_e          sel;
   logic [BIDX_W-1:0] bank;

   gpio_addr_dec #(
      .ADDR_W     (ADDR_W),
      .NBANKS     (NBANKS),
      .VALUE_BASE (VALUE_BASE),
      .DIR_BASE   (DIR_BASE),
      .MODE_BASE  (MODE_BASE)
   ) u_dec (
      .addr (addr),
      .sel  (sel),
      .bank (bank)
   );

   logic [NPINS-1:0] level_all;
   logic [NPINS-1:0] dir_all;
   logic [NPINS-1:0] mode_all;
   logic [NPINS-1:0] open_all;

   gpio_sync #(
      .WIDTH  (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (level_all)
   );

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic hit;
      assign hit = we && (bank == BIDX_W'(b));

      gpio_bank #(
         .BANK_W (BANK_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wdata    (wdata),
         .wr_value (hit && (sel == SEL_VALUE)),
         .wr_mask  (hit && (sel == SEL_MASK)),
         .wr_dir   (hit && (sel == SEL_DIR)),
         .wr_mode  (hit && (sel == SEL_MODE)),
         .wr_open  (hit && (sel == SEL_OPEN)),
         .out_q    (pad_out [b*BANK_W +: BANK_W]),
         .oe       (pad_oe  [b*BANK_W +: BANK_W]),
         .dir_q    (dir_all [b*BANK_W +: BANK_W]),
         .mode_q   (mode_all[b*BANK_W +: BANK_W]),
         .open_q   (open_all[b*BANK_W +: BANK_W])
      );
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NBANKS; b++) begin
         if (bank == BIDX_W'(b)) begin
            case (sel)
               SEL_VALUE: rdata = level_all[b*BANK_W +: BANK_W];
               SEL_DIR:   rdata = dir_all  [b*BANK_W +: BANK_W];
               SEL_MODE:  rdata = mode_all [b*BANK_W +: BANK_W];
               SEL_OPEN:  rdata = open_all [b*BANK_W +: BANK_W];
               default:   rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
   parameter int ADDR_W     = 5,
   parameter int NBANKS     = 3,
   parameter int BANK_W     = 8,
   parameter int VALUE_BASE = 0,
   localparam int NPINS     = NBANKS * BANK_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BANK_W-1:0] wdata,
   input logic              we,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  dir_all,
   input logic [NPINS-1:0]  mode_all,
   input logic [NPINS-1:0]  open_all
);

   logic value_wr;
   logic mask_wr;

   always_comb begin
      value_wr = 1'b0;
      mask_wr  = 1'b0;
      for (int b = 0; b < NBANKS; b++) begin
         if (we && addr == ADDR_W'(VALUE_BASE + 2*b))     value_wr = 1'b1;
         if (we && addr == ADDR_W'(VALUE_BASE + 2*b + 1)) mask_wr  = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rst_n == 1'b0) begin
         assert_reset_quiet_R1: assert (pad_oe == '0 && pad_out == '0);
      end
   end

   assert_value_alone_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      value_wr |=> $stable(pad_out));

   assert_zero_mask_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && wdata == '0) |=> $stable(pad_out));

   assert_input_never_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_all) == '0);

   assert_sink_only_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & open_all & ~mode_all & pad_out) == '0);

   assert_source_only_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & open_all & mode_all & ~pad_out) == '0);

   assert_push_pull_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_all & ~open_all & ~pad_oe) == '0);

endmodule

bind gpio_port_masked gpio_port_checker #(
   .ADDR_W     (ADDR_W),
   .NBANKS     (NBANKS),
   .BANK_W     (BANK_W),
   .VALUE_BASE (VALUE_BASE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wdata    (wdata),
   .we       (we),
   .pad_out  (pad_out),
   .pad_oe   (pad_oe),
   .dir_all  (dir_all),
   .mode_all (mode_all),
   .open_all (open_all)
);

// File: tb/sim_gpio_port_masked.sv
module sim_gpio_port_masked;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        we = 1'b0;
   logic [7:0]  rdata;
   logic [23:0] pad_in = '0;
   logic [23:0] pad_out;
   logic [23:0] pad_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   gpio_port_masked u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wdata   (wdata),
      .we      (we),
      .rdata   (rdata),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      we = 1'b0; addr = a;
      #1;
      d = rdata;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      logic [7:0] acc;
      check("R1", "pad_out after reset", 32'(pad_out), 32'h0);
      check("R1", "pad_oe after reset", 32'(pad_oe), 32'h0);
      acc = '0;
      for (int b = 0; b < 3; b++) begin
         rd(5'(8 + b), v);       acc |= v;
         rd(5'(16 + 2*b), v);    acc |= v;
         rd(5'(17 + 2*b), v);    acc |= v;
      end
      check("R1", "config registers after reset", 32'(acc), 32'h0);
   endtask

   task automatic t_value_only;
      wr(5'h02, 8'hFF);
      check("R3", "value byte alone", 32'(pad_out), 32'h0);
   endtask

   task automatic t_masked;
      wr(5'h03, 8'h0F);
      check("R2", "mask low nibble", 32'(pad_out), 32'h000F00);
      wr(5'h02, 8'h00);
      wr(5'h03, 8'h05);
      check("R2", "mask clears bits 0 and 2", 32'(pad_out), 32'h000A00);
      wr(5'h03, 8'h80);
      check("R2", "reused staged zero", 32'(pad_out), 32'h000A00);
      wr(5'h04, 8'h81);
      wr(5'h05, 8'hFF);
      check("R9", "bank 2 write leaves others", 32'(pad_out), 32'h810A00);
      check("R4", "inputs not enabled", 32'(pad_oe), 32'h0);
   endtask

   task automatic t_direction;
      logic [7:0] v;
      wr(5'h09, 8'hF0);
      rd(5'h09, v);
      check("R4", "direction readback", 32'(v), 32'hF0);
      check("R5", "push-pull enables both levels", 32'(pad_oe), 32'h00F000);
   endtask

   task automatic t_open_drain;
      logic [7:0] v;
      wr(5'h0A, 8'hFF);
      wr(5'h15, 8'hFF);
      wr(5'h14, 8'h00);
      check("R6", "open-drain enables only low", 32'(pad_oe[23:16]), 32'h7E);
      rd(5'h15, v);
      check("R10", "open-enable readback", 32'(v), 32'hFF);
   endtask

   task automatic t_open_source;
      logic [7:0] v;
      wr(5'h14, 8'hFF);
      check("R7", "open-source enables only high", 32'(pad_oe[23:16]), 32'h81);
      wr(5'h14, 8'h0F);
      check("R7", "mixed source and drain", 32'(pad_oe[23:16]), 32'h71);
      rd(5'h14, v);
      check("R10", "drive-mode readback", 32'(v), 32'h0F);
      wr(5'h15, 8'h00);
      check("R5", "back to push-pull", 32'(pad_oe[23:16]), 32'hFF);
   endtask

   task automatic t_sync_overlap;
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rd(5'h00, v);
      check("R8", "settled level before change", 32'(v), 32'h00);
      wr(5'h00, 8'h66);
      @(negedge clk);
      addr = 5'h01; wdata = 8'hFF; we = 1'b1;
      pad_in = 24'h5A3CC3;
      @(negedge clk);
      we = 1'b0;
      check("R2", "mask write alongside pad change", 32'(pad_out[7:0]), 32'h66);
      rd(5'h00, v);
      check("R8", "level not visible after one edge", 32'(v), 32'h00);
      @(negedge clk);
      rd(5'h00, v);
      check("R8", "bank 0 level after two edges", 32'(v), 32'hC3);
      rd(5'h02, v);
      check("R9", "bank 1 level", 32'(v), 32'h3C);
      rd(5'h04, v);
      check("R9", "bank 2 level", 32'(v), 32'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_value_only;
      t_masked;
      t_direction;
      t_open_drain;
      t_open_source;
      t_sync_overlap;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule